// File: doc/BRIEF.md
# Dual-Port Register Access Arbiter

This block lets two control ports share one register and RAM address space. One port is a synchronous serial port; its frame decoder sits outside this block and shows up here as a request, grant and done handshake with an address, write data and a write flag. The other port is an 8-bit microprocessor port. A chip-select that is held active starts each single-register transfer on that port. The register file sits behind a plain single-cycle bus. A write happens on any clock edge where the write-enable is high. Read data is combinational from the address.

The block gives the register bus to one port at a time. When the two ports ask for the bus in the same cycle, the serial port wins. The serial port cannot break into a microprocessor transfer that has already started. A static input selects the microprocessor handshake style. In ready style (`cfg_bus_mode` = 0), the ready output stays low until the host's transfer is done, and it also stays low while the serial port holds the bus. In acknowledge style (`cfg_bus_mode` = 1), a one-cycle acknowledge pulse is sent only after any serial access ahead of it has finished.

Top module: `reg_access_arbiter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the bus is idle: `ser_gnt`=0, `rb_we`=0, `rb_addr`=0, `mp_ack`=0 and `mp_rdata`=0. `mp_rdy` is 1 in ready style with chip-select low, and 0 in acknowledge style.
- R2: If `ser_req` is high on a clock edge while the bus is idle, `ser_gnt` is 1 in the next cycle. This holds even when a new microprocessor chip-select was sampled on the same edge. That microprocessor access then waits.
- R3: A microprocessor transfer starts when chip-select is sampled high while the bus is idle and no serial request is present. That transfer runs to completion, one transfer cycle and then one completion cycle. A serial request raised during it is granted only after it ends, with one idle cycle in between.
- R4: Only the granted port drives the register bus. In serial grant cycles, `rb_addr`/`rb_wdata`/`rb_we` carry the serial fields. In the single microprocessor transfer cycle they carry the microprocessor fields. In every other cycle they are all zero.
- R5: During serial grant, `ser_rdata` equals `rb_rdata`, and it is zero otherwise. `mp_rdata` takes the value `rb_rdata` had in the microprocessor transfer cycle. It shows that value from the completion cycle on and holds it until the next transfer.
- R6: In ready style, `mp_rdy` is 0 whenever chip-select is high and the access is not yet completed, and also during any serial grant. It is 1 in the completion cycle and whenever no microprocessor access is outstanding. In acknowledge style, `mp_rdy` is always 0.
- R7: In acknowledge style, `mp_ack` is 1 for exactly the completion cycle of each microprocessor transfer, and never during a serial grant. In ready style, `mp_ack` is always 0.
- R8: If `ser_done` is sampled during a serial grant while a microprocessor access is waiting, the microprocessor transfer cycle follows in the very next cycle. The completion cycle comes after it.
- R9: Once a microprocessor access has completed, holding chip-select high starts no new transfer. A new access needs chip-select to be sampled low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bus_mode | input | 1 | Static handshake style: 0 ready, 1 acknowledge |
| ser_req | input | 1 | Serial side requests the bus |
| ser_done | input | 1 | Serial side finished its access (sampled during grant) |
| ser_addr | input | ADDR_W | Serial access address |
| ser_wdata | input | DATA_W | Serial write data |
| ser_we | input | 1 | Serial write flag |
| ser_gnt | output | 1 | Bus granted to serial side |
| ser_rdata | output | DATA_W | Read data to serial side |
| mp_cs | input | 1 | Microprocessor chip-select, held until completion |
| mp_we | input | 1 | Microprocessor write flag |
| mp_addr | input | ADDR_W | Microprocessor address |
| mp_wdata | input | DATA_W | Microprocessor write data |
| mp_rdata | output | DATA_W | Captured read data to microprocessor |
| mp_rdy | output | 1 | Ready line (ready style) |
| mp_ack | output | 1 | Acknowledge pulse (acknowledge style) |
| rb_addr | output | ADDR_W | Register bus address |
| rb_wdata | output | DATA_W | Register bus write data |
| rb_we | output | 1 | Register bus write-enable |
| rb_rdata | input | DATA_W | Register bus read data |

## Verification
Suppose the arbiter's state register is wrong, for example it takes the wrong branch when both requests arrive at once. The error shows at the ports within one cycle: `ser_gnt` appears or is missing, or the register bus carries the other port's address. If the served flag is wrong, the fault is seen one cycle after the completion cycle. Either a second write strobe appears while chip-select is held, or the ready line stays low. A wrong read-data capture shows in the completion cycle as a wrong `mp_rdata`. All of these are caught by a per-cycle comparison against a behavioural model that keeps its own copy of the register contents.

// File: rtl/rarb_pkg.sv
package rarb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SER   = 2'd1,
    ST_MPX   = 2'd2,
    ST_MPEND = 2'd3
  } arb_st_e;
endpackage

// File: rtl/rarb_ctrl.sv
module rarb_ctrl
  import rarb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ser_req,
  input  logic    ser_done,
  input  logic    mp_cs,
  output arb_st_e st,
  output logic    served
);
  arb_st_e st_n;
  logic    served_n;
  logic    mp_waiting;

  assign mp_waiting = mp_cs && !served;

  always_comb begin
    st_n     = st;
    served_n = mp_cs ? served : 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (ser_req)         st_n = ST_SER;
        else if (mp_waiting) st_n = ST_MPX;
      end
      ST_SER: begin
        if (ser_done) st_n = mp_waiting ? ST_MPX : ST_IDLE;
      end
      ST_MPX:   st_n = ST_MPEND;
      ST_MPEND: begin
        st_n     = ST_IDLE;
        served_n = mp_cs;
      end
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      served <= 1'b0;
    end else begin
      st     <= st_n;
      served <= served_n;
    end
  end
endmodule

// File: rtl/rarb_busmux.sv
module rarb_busmux
  import rarb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  arb_st_e           st,
  input  logic [ADDR_W-1:0] ser_addr,
  input  logic [DATA_W-1:0] ser_wdata,
  input  logic              ser_we,
  input  logic [ADDR_W-1:0] mp_addr,
  input  logic [DATA_W-1:0] mp_wdata,
  input  logic              mp_we,
  input  logic [DATA_W-1:0] rb_rdata,
  output logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_wdata,
  output logic              rb_we,
  output logic [DATA_W-1:0] ser_rdata
);
  always_comb begin
    rb_addr   = '0;
    rb_wdata  = '0;
    rb_we     = 1'b0;
    ser_rdata = '0;
    unique case (st)
      ST_SER: begin
        rb_addr   = ser_addr;
        rb_wdata  = ser_wdata;
        rb_we     = ser_we;
        ser_rdata = rb_rdata;
      end
      ST_MPX: begin
        rb_addr  = mp_addr;
        rb_wdata = mp_wdata;
        rb_we    = mp_we;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rarb_mp_resp.sv
module rarb_mp_resp
  import rarb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bus_mode,
  input  arb_st_e           st,
  input  logic              served,
  input  logic              mp_cs,
  input  logic [DATA_W-1:0] rb_rdata,
  output logic [DATA_W-1:0] mp_rdata,
  output logic              mp_rdy,
  output logic              mp_ack
);
  logic outstanding;
  logic finishing;

  assign outstanding = mp_cs && !served;
  assign finishing   = (st == ST_MPEND);

  always_ff @(posedge clk) begin
    if (rst)                mp_rdata <= '0;
    else if (st == ST_MPX)  mp_rdata <= rb_rdata;
  end

  assign mp_rdy = !cfg_bus_mode &&
                  (finishing || (st == ST_IDLE && !outstanding));
  assign mp_ack = cfg_bus_mode && finishing;
endmodule

// File: rtl/reg_access_arbiter.sv
module reg_access_arbiter
  import rarb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bus_mode,
  input  logic              ser_req,
  input  logic              ser_done,
  input  logic [ADDR_W-1:0] ser_addr,
  input  logic [DATA_W-1:0] ser_wdata,
  input  logic              ser_we,
  output logic              ser_gnt,
  output logic [DATA_W-1:0] ser_rdata,
  input  logic              mp_cs,
  input  logic              mp_we,
  input  logic [ADDR_W-1:0] mp_addr,
  input  logic [DATA_W-1:0] mp_wdata,
  output logic [DATA_W-1:0] mp_rdata,
  output logic              mp_rdy,
  output logic              mp_ack,
  output logic [ADDR_W-1:0] rb_addr,
  output logic [DATA_W-1:0] rb_wdata,
  output logic              rb_we,
  input  logic [DATA_W-1:0] rb_rdata
);
  arb_st_e st;
  logic    served;

  rarb_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ser_req  (ser_req),
    .ser_done (ser_done),
    .mp_cs    (mp_cs),
    .st       (st),
    .served   (served)
  );

  rarb_busmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .st        (st),
    .ser_addr  (ser_addr),
    .ser_wdata (ser_wdata),
    .ser_we    (ser_we),
    .mp_addr   (mp_addr),
    .mp_wdata  (mp_wdata),
    .mp_we     (mp_we),
    .rb_rdata  (rb_rdata),
    .rb_addr   (rb_addr),
    .rb_wdata  (rb_wdata),
    .rb_we     (rb_we),
    .ser_rdata (ser_rdata)
  );

  rarb_mp_resp #(.DATA_W(DATA_W)) u_resp (
    .clk          (clk),
    .rst          (rst),
    .cfg_bus_mode (cfg_bus_mode),
    .st           (st),
    .served       (served),
    .mp_cs        (mp_cs),
    .rb_rdata     (rb_rdata),
    .mp_rdata     (mp_rdata),
    .mp_rdy       (mp_rdy),
    .mp_ack       (mp_ack)
  );

  assign ser_gnt = (st == ST_SER);
endmodule

// File: rtl/rarb_checker.sv
module rarb_checker
  import rarb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_bus_mode,
  input logic              ser_req,
  input logic              ser_done,
  input logic              ser_gnt,
  input logic              mp_cs,
  input logic              mp_rdy,
  input logic              mp_ack,
  input logic              rb_we,
  input logic [DATA_W-1:0] mp_rdata,
  input arb_st_e           st,
  input logic              served
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!ser_gnt && !rb_we && !mp_ack)); // R1
  AST_SERIAL_WINS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && ser_req) |=> ser_gnt); // R2
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MPX) |=> (st == ST_MPEND && !ser_gnt)); // R3
  AST_WE_ONLY_GRANTED: assert property (@(posedge clk) disable iff (rst)
    rb_we |-> (ser_gnt || st == ST_MPX)); // R4
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (st != ST_MPX) |=> $stable(mp_rdata)); // R5
  AST_RDY_LOW_IN_SERIAL: assert property (@(posedge clk) disable iff (rst)
    ser_gnt |-> !mp_rdy); // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mp_ack |=> !mp_ack); // R7
  AST_ACK_STYLE: assert property (@(posedge clk) disable iff (rst)
    mp_ack |-> (cfg_bus_mode && !ser_gnt)); // R7
  AST_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    (ser_gnt && ser_done && mp_cs && !served) |=> (st == ST_MPX)); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MPEND && mp_cs) |=> ##1 (mp_cs |-> st != ST_MPX)); // R9
endmodule

bind reg_access_arbiter rarb_checker #(.DATA_W(DATA_W)) u_rarb_checker (
  .clk          (clk),
  .rst          (rst),
  .cfg_bus_mode (cfg_bus_mode),
  .ser_req      (ser_req),
  .ser_done     (ser_done),
  .ser_gnt      (ser_gnt),
  .mp_cs        (mp_cs),
  .mp_rdy       (mp_rdy),
  .mp_ack       (mp_ack),
  .rb_we        (rb_we),
  .mp_rdata     (mp_rdata),
  .st           (st),
  .served       (served)
);

// File: tb/tb_reg_access_arbiter.sv
module tb_reg_access_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_bus_mode = 1'b0;
  logic ser_req = 1'b0, ser_done = 1'b0, ser_we = 1'b0;
  logic [AW-1:0] ser_addr = '0;
  logic [DW-1:0] ser_wdata = '0;
  logic ser_gnt;
  logic [DW-1:0] ser_rdata;
  logic mp_cs = 1'b0, mp_we = 1'b0;
  logic [AW-1:0] mp_addr = '0;
  logic [DW-1:0] mp_wdata = '0;
  logic [DW-1:0] mp_rdata;
  logic mp_rdy, mp_ack;
  logic [AW-1:0] rb_addr;
  logic [DW-1:0] rb_wdata;
  logic rb_we;
  logic [DW-1:0] rb_rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_access_arbiter #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .cfg_bus_mode(cfg_bus_mode),
    .ser_req(ser_req), .ser_done(ser_done), .ser_addr(ser_addr),
    .ser_wdata(ser_wdata), .ser_we(ser_we), .ser_gnt(ser_gnt),
    .ser_rdata(ser_rdata), .mp_cs(mp_cs), .mp_we(mp_we),
    .mp_addr(mp_addr), .mp_wdata(mp_wdata), .mp_rdata(mp_rdata),
    .mp_rdy(mp_rdy), .mp_ack(mp_ack), .rb_addr(rb_addr),
    .rb_wdata(rb_wdata), .rb_we(rb_we), .rb_rdata(rb_rdata)
  );

  // register file behind the bus
  logic [DW-1:0] regs [DEPTH];
  assign rb_rdata = regs[rb_addr];
  always @(posedge clk) if (rb_we) regs[rb_addr] <= rb_wdata;

  // behavioural reference: 0 idle, 1 serial owns bus, 2 micro transfer, 3 micro completion
  int ph;
  bit done_flag;
  logic [DW-1:0] exp_mrd;
  logic [DW-1:0] shadow [DEPTH];

  task automatic model_reset();
    ph = 0; done_flag = 0; exp_mrd = '0;
  endtask

  task automatic model_edge();
    int nph;
    bit nflag;
    nph = ph;
    nflag = mp_cs ? done_flag : 1'b0;
    if (ph == 0) begin
      if (ser_req) nph = 1;
      else if (mp_cs && !done_flag) nph = 2;
    end else if (ph == 1) begin
      if (ser_we) shadow[ser_addr] = ser_wdata;
      if (ser_done) nph = (mp_cs && !done_flag) ? 2 : 0;
    end else if (ph == 2) begin
      exp_mrd = shadow[mp_addr];
      if (mp_we) shadow[mp_addr] = mp_wdata;
      nph = 3;
    end else begin
      nph = 0;
      nflag = mp_cs;
    end
    ph = nph;
    done_flag = nflag;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    logic [AW-1:0] ea;
    logic [DW-1:0] ew;
    logic ewe, erdy;
    ea = '0; ew = '0; ewe = 1'b0;
    if (ph == 1) begin ea = ser_addr; ew = ser_wdata; ewe = ser_we; end
    if (ph == 2) begin ea = mp_addr; ew = mp_wdata; ewe = mp_we; end
    erdy = !cfg_bus_mode && (ph == 3 || (ph == 0 && !(mp_cs && !done_flag)));
    chk("R2 ser_gnt", 32'(ser_gnt), 32'(ph == 1));
    chk("R4 rb_addr", 32'(rb_addr), 32'(ea));
    chk("R4 rb_wdata", 32'(rb_wdata), 32'(ew));
    chk("R4 rb_we", 32'(rb_we), 32'(ewe));
    chk("R5 ser_rdata", 32'(ser_rdata), (ph == 1) ? 32'(shadow[ser_addr]) : 32'd0);
    chk("R5 mp_rdata", 32'(mp_rdata), 32'(exp_mrd));
    chk("R6 mp_rdy", 32'(mp_rdy), 32'(erdy));
    chk("R7 mp_ack", 32'(mp_ack), 32'(cfg_bus_mode && ph == 3));
  endtask

  // inputs are set at the falling edge; compare shortly after, then advance one clock
  task automatic step();
    #1;
    if (!rst) compare_model();
    @(posedge clk);
    if (rst) model_reset(); else model_edge();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      regs[i] = DW'(i * 7 + 3);
      shadow[i] = DW'(i * 7 + 3);
    end
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      // reset
      rst = 1'b1; cfg_bus_mode = m[0];
      ser_req = 0; ser_done = 0; ser_we = 0; mp_cs = 0; mp_we = 0;
      model_reset();
      step(); step();
      chk("R1 gnt in reset", 32'(ser_gnt), 0);
      chk("R1 ack in reset", 32'(mp_ack), 0);
      rst = 1'b0;
      #1;
      chk("R1 gnt", 32'(ser_gnt), 0);
      chk("R1 we", 32'(rb_we), 0);
      chk("R1 addr", 32'(rb_addr), 0);
      chk("R1 mp_rdata", 32'(mp_rdata), 0);
      chk("R1 rdy", 32'(mp_rdy), 32'(m == 0));
      chk("R1 ack", 32'(mp_ack), 0);
      step();

      // micro write then read back alone
      mp_cs = 1; mp_we = 1; mp_addr = 6'd5; mp_wdata = 8'hA5;
      step(); step();
      chk("R6 completion rdy", 32'(mp_rdy), 32'(m == 0));
      chk("R7 completion ack", 32'(mp_ack), 32'(m == 1));
      mp_cs = 0; step();
      mp_cs = 1; mp_we = 0;
      step(); step();
      chk("R5 read back", 32'(mp_rdata), 32'h A5);
      mp_cs = 0; step();

      // simultaneous request: serial wins, micro follows after done
      ser_req = 1; ser_we = 1; ser_addr = 6'd9; ser_wdata = 8'h3C;
      mp_cs = 1; mp_we = 0; mp_addr = 6'd9;
      step();
      chk("R2 serial first", 32'(ser_gnt), 1);
      chk("R6 rdy held low", 32'(mp_rdy), 0);
      chk("R7 no ack in serial", 32'(mp_ack), 0);
      step();
      ser_done = 1; ser_req = 0;
      step();
      ser_done = 0;
      #1;
      chk("R8 micro right after done", 32'(rb_addr), 32'd9);
      chk("R8 micro not serial", 32'(ser_gnt), 0);
      step();
      chk("R8 read sees serial write", 32'(mp_rdata), 32'h3C);
      chk("R8 completion", 32'(m == 0 ? mp_rdy : mp_ack), 1);
      mp_cs = 0; step();

      // serial request during a micro transfer waits
      mp_cs = 1; mp_we = 1; mp_addr = 6'd12; mp_wdata = 8'h77;
      step();
      ser_req = 1; ser_we = 0; ser_addr = 6'd12;
      #1;
      chk("R3 no grant mid transfer", 32'(ser_gnt), 0);
      step();
      chk("R3 no grant at completion", 32'(ser_gnt), 0);
      chk("R3 completion", 32'(m == 0 ? mp_rdy : mp_ack), 1);
      mp_cs = 0; step();
      chk("R3 idle gap", 32'(ser_gnt), 0);
      step();
      chk("R3 grant after", 32'(ser_gnt), 1);
      chk("R3 serial reads micro data", 32'(ser_rdata), 32'h77);
      ser_done = 1; ser_req = 0; step();
      ser_done = 0; step();

      // chip-select held after completion starts nothing new
      mp_cs = 1; mp_we = 1; mp_addr = 6'd20; mp_wdata = 8'h11;
      step(); step();
      for (int k = 0; k < 3; k++) begin
        step();
        chk("R9 no new strobe", 32'(rb_we), 0);
        chk("R9 no new ack", 32'(mp_ack), 0);
        chk("R9 rdy stays", 32'(mp_rdy), 32'(m == 0));
      end
      mp_cs = 0; step(); step();
    end
    finish_run();
  end
endmodule